// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear/Toggle Aliases

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pin banks. Each pin has a two-bit function selector that hands the pad either to software-controlled I/O or to one of up to three peripheral functions. In I/O mode, the pad is driven by a direction register and a separate output-data register. The pad level is read back through a separate input register that is fed by a two-flop synchroniser.

Every register sits at four consecutive word addresses: a plain location, a set alias, a clear alias and a toggle alias. Software can therefore change single bits with one write and no read-modify-write sequence. Each pin also has interrupt logic with enable, level/edge choice, polarity and a sticky status bit. Each bank drives one combined interrupt line. Register reads are combinational from the address, with no read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The address is decoded as follows. bus_addr[11:8] is the bank. bus_addr[7:4] is the register: 0 function select, 1 output enable, 2 output data, 3 input, 4 irq enable, 5 irq type (1 = edge), 6 irq polarity (1 = high/rising), 7 irq status. bus_addr[3:2] is the alias: 0 plain, 1 set, 2 clear, 3 toggle. A read from any alias returns the register value in the same cycle. A read of an unmapped register or a bank at or above NB returns 0, and a write there changes nothing.
- R2: A plain-alias write replaces the register. A set-alias write sets each bit that is 1 in the write data and leaves the others as they were.
- R3: A clear-alias write clears each bit that is 1 in the write data and leaves the others as they were.
- R4: A toggle-alias write inverts each bit that is 1 in the write data and leaves the others as they were.
- R5: The function field of pin i is bits [2i+1:2i] of the bank's select register. When it holds 3 (I/O), pad_out and pad_oe for the pin follow the output-data and output-enable bits.
- R6: When the field holds 0 to 2, pad_out and pad_oe for global pin g come from per_out and per_oe at index g*NFUNC+field. Output-data and output-enable writes then have no effect on that pad.
- R7: After reset, output enable, output data and all interrupt registers are 0, and irq is 0. Every function field loads the MUX_RESET value. By default, pins 6 and 7 of bank 1 select function 0 (bank 1 select reads 0x0FFF) and all other pins select I/O.
- R8: The input register shows pad_in through two flip-flops. A change driven before one rising edge reads as the old value after that edge and as the new value after the next edge. Writes to the input register through any alias are ignored.
- R9: With irq type 0, an enabled pin sets its status bit on each clock while its synchronised input equals the polarity bit.
- R10: With irq type 1, an enabled pin sets its status bit on a synchronised rising transition when the polarity is 1, or on a falling transition when the polarity is 0.
- R11: A status bit is sticky. Only a clear-alias write with 1 in that bit clears it. Plain, set and toggle writes to the status register are ignored, and a new event in the same cycle wins over a clear.
- R12: irq[b] is the OR over bank b of status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NB*P | Pad input levels, asynchronous |
| pad_out | output | NB*P | Pad output levels |
| pad_oe | output | NB*P | Pad output enables |
| per_out | input | NB*P*NFUNC | Peripheral output per pin and function |
| per_oe | input | NB*P*NFUNC | Peripheral output enable per pin and function |
| irq | output | NB | Combined interrupt per bank |

## Verification
A wrong alias decode shows as a wrong register value on the read immediately after the write. Because every register is readable, the error is visible within two cycles. A corrupted function field or a mis-routed pad mux shows at once on pad_out/pad_oe when per_out, per_oe or the output-data register change. A fault in the synchroniser or in edge detection shifts the input readback or the status bit by one or more cycles, so the bench samples at the exact edge count. A status bit that is not sticky disappears from the status read and from irq when the input level returns to its idle state.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        AL_PLAIN = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TOG   = 2'd3
    } alias_e;

    typedef enum logic [3:0] {
        RG_FSEL  = 4'd0,
        RG_OE    = 4'd1,
        RG_DOUT  = 4'd2,
        RG_DIN   = 4'd3,
        RG_IEN   = 4'd4,
        RG_ITYPE = 4'd5,
        RG_IPOL  = 4'd6,
        RG_ISTAT = 4'd7
    } reg_e;

    localparam logic [1:0] FSEL_IO = 2'd3;

    typedef struct packed {
        logic [3:0] bank;
        logic [3:0] kind;
        alias_e     al;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(input logic [11:0] addr);
        bus_dec_t d;
        d.bank = addr[11:8];
        d.kind = addr[7:4];
        d.al   = alias_e'(addr[3:2]);
        return d;
    endfunction

    function automatic logic [31:0] apply_alias(input logic [31:0] cur,
                                                input logic [31:0] wd,
                                                input alias_e al);
        case (al)
            AL_PLAIN: return wd;
            AL_SET:   return cur | wd;
            AL_CLR:   return cur & ~wd;
            default:  return cur ^ wd;
        endcase
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  alias_e       al,
    input  logic [31:0]  wd,
    output logic [W-1:0] q
);
    logic [31:0] nxt;

    always_comb nxt = apply_alias(32'(q), wd, al);

    always_ff @(posedge clk) begin
        if (rst)     q <= RST;
        else if (we) q <= nxt[W-1:0];
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int P = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [P-1:0] din,
    input  logic [P-1:0] en,
    input  logic [P-1:0] edge_mode,
    input  logic [P-1:0] pol,
    input  logic         clr_we,
    input  logic [P-1:0] clr_mask,
    output logic [P-1:0] stat,
    output logic         irq
);
    logic [P-1:0] prev;
    logic [P-1:0] hit;

    always_comb begin
        for (int i = 0; i < P; i++) begin
            if (edge_mode[i])
                hit[i] = en[i] & (pol[i] ? (din[i] & ~prev[i]) : (~din[i] & prev[i]));
            else
                hit[i] = en[i] & (din[i] == pol[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            stat <= '0;
        end else begin
            prev <= din;
            stat <= (stat & ~(clr_we ? clr_mask : '0)) | hit;
        end
    end

    assign irq = |(stat & en);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NB    = 2,
    parameter int P     = 8,
    parameter int NFUNC = 3,
    parameter logic [NB*2*P-1:0] MUX_RESET = {4'b0000, {(NB*2*P-4){1'b1}}}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NB*P-1:0]       pad_in,
    output logic [NB*P-1:0]       pad_out,
    output logic [NB*P-1:0]       pad_oe,
    input  logic [NB*P*NFUNC-1:0] per_out,
    input  logic [NB*P*NFUNC-1:0] per_oe,
    output logic [NB-1:0]         irq
);
    localparam int NPIN = NB * P;
    localparam int FW   = 2 * P;
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1;

    bus_dec_t dec;
    logic     bank_ok;
    logic [BW-1:0] bsel;

    always_comb begin
        dec     = decode_addr(bus_addr);
        bank_ok = (dec.bank < 4'(NB));
        bsel    = dec.bank[BW-1:0];
    end

    logic [NB-1:0][FW-1:0] fsel_q;
    logic [NB-1:0][P-1:0]  oe_q, dout_q, din_q, ien_q, ityp_q, ipol_q, stat_q;

    logic [NPIN-1:0]   oe_flat, dout_flat, stat_flat;
    logic [NB*FW-1:0]  fsel_flat;
    assign oe_flat   = oe_q;
    assign dout_flat = dout_q;
    assign stat_flat = stat_q;
    assign fsel_flat = fsel_q;

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(din_q)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit_b;
        assign hit_b = bus_wr && (dec.bank == 4'(b));

        gpio_alias_reg #(.W(FW), .RST(MUX_RESET[b*FW +: FW])) u_fsel (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_FSEL),
            .al(dec.al), .wd(bus_wdata), .q(fsel_q[b])
        );
        gpio_alias_reg #(.W(P)) u_oe (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_OE),
            .al(dec.al), .wd(bus_wdata), .q(oe_q[b])
        );
        gpio_alias_reg #(.W(P)) u_dout (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_DOUT),
            .al(dec.al), .wd(bus_wdata), .q(dout_q[b])
        );
        gpio_alias_reg #(.W(P)) u_ien (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_IEN),
            .al(dec.al), .wd(bus_wdata), .q(ien_q[b])
        );
        gpio_alias_reg #(.W(P)) u_ityp (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_ITYPE),
            .al(dec.al), .wd(bus_wdata), .q(ityp_q[b])
        );
        gpio_alias_reg #(.W(P)) u_ipol (
            .clk(clk), .rst(rst), .we(hit_b && dec.kind == RG_IPOL),
            .al(dec.al), .wd(bus_wdata), .q(ipol_q[b])
        );

        gpio_irq_bank #(.P(P)) u_irq (
            .clk(clk), .rst(rst), .din(din_q[b]), .en(ien_q[b]),
            .edge_mode(ityp_q[b]), .pol(ipol_q[b]),
            .clr_we(hit_b && dec.kind == RG_ISTAT && dec.al == AL_CLR),
            .clr_mask(bus_wdata[P-1:0]), .stat(stat_q[b]), .irq(irq[b])
        );

        for (genvar i = 0; i < P; i++) begin : g_pin
            localparam int G = b * P + i;
            logic [1:0] fs;
            assign fs = fsel_q[b][2*i +: 2];
            always_comb begin
                if (fs == FSEL_IO) begin
                    pad_out[G] = dout_q[b][i];
                    pad_oe[G]  = oe_q[b][i];
                end else if (int'(fs) < NFUNC) begin
                    pad_out[G] = per_out[G*NFUNC + int'(fs)];
                    pad_oe[G]  = per_oe[G*NFUNC + int'(fs)];
                end else begin
                    pad_out[G] = 1'b0;
                    pad_oe[G]  = 1'b0;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bank_ok) begin
            case (dec.kind)
                RG_FSEL:  bus_rdata = 32'(fsel_q[bsel]);
                RG_OE:    bus_rdata = 32'(oe_q[bsel]);
                RG_DOUT:  bus_rdata = 32'(dout_q[bsel]);
                RG_DIN:   bus_rdata = 32'(din_q[bsel]);
                RG_IEN:   bus_rdata = 32'(ien_q[bsel]);
                RG_ITYPE: bus_rdata = 32'(ityp_q[bsel]);
                RG_IPOL:  bus_rdata = 32'(ipol_q[bsel]);
                RG_ISTAT: bus_rdata = 32'(stat_q[bsel]);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NB = 2,
    parameter int P  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NB*P-1:0]   dout_flat,
    input logic [NB*P-1:0]   oe_flat,
    input logic [NB*P-1:0]   stat_flat,
    input logic [NB*2*P-1:0] fsel_flat,
    input logic [NB*P-1:0]   pad_oe
);
    logic dout0_wr;
    assign dout0_wr = bus_wr && bus_addr[11:8] == 4'd0 && bus_addr[7:4] == 4'd2;

    assert_dout_set_R2: assert property (@(posedge clk) disable iff (rst)
        (dout0_wr && bus_addr[3:2] == 2'd1) |=>
        dout_flat[P-1:0] == ($past(dout_flat[P-1:0]) | $past(bus_wdata[P-1:0])));

    assert_dout_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (dout0_wr && bus_addr[3:2] == 2'd2) |=>
        dout_flat[P-1:0] == ($past(dout_flat[P-1:0]) & ~$past(bus_wdata[P-1:0])));

    assert_dout_tog_R4: assert property (@(posedge clk) disable iff (rst)
        (dout0_wr && bus_addr[3:2] == 2'd3) |=>
        dout_flat[P-1:0] == ($past(dout_flat[P-1:0]) ^ $past(bus_wdata[P-1:0])));

    assert_stat_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr[7:4] == 4'd7 && bus_addr[3:2] == 2'd2) |=>
        ((stat_flat & $past(stat_flat)) == $past(stat_flat)));

    for (genvar g = 0; g < NB*P; g++) begin : g_pin
        assert_io_oe_R5: assert property (@(posedge clk) disable iff (rst)
            (fsel_flat[2*g +: 2] == 2'd3) |-> (pad_oe[g] == oe_flat[g]));
    end
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NB(NB), .P(P)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dout_flat(dout_flat), .oe_flat(oe_flat),
    .stat_flat(stat_flat), .fsel_flat(fsel_flat), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    localparam int NB = 2, P = 8, NFUNC = 3, NPIN = NB * P;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe;
    logic [NPIN*NFUNC-1:0] per_out = '0, per_oe = '0;
    logic [NB-1:0] irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NB(NB), .P(P), .NFUNC(NFUNC)) u_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out),
        .per_oe(per_oe), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  req;
    } vec_t;

    // R7 reset select, R2 plain/set, R3 clear, R4 toggle, R8 input ignores writes, R1 unmapped
    localparam vec_t VEC [10] = '{
        '{12'h104, 32'h0,  12'h100, 32'h0FFF, 8'd7},
        '{12'h020, 32'hA5, 12'h020, 32'hA5,   8'd2},
        '{12'h024, 32'h0F, 12'h020, 32'hAF,   8'd2},
        '{12'h028, 32'hA0, 12'h02C, 32'h0F,   8'd3},
        '{12'h02C, 32'hFF, 12'h020, 32'hF0,   8'd4},
        '{12'h110, 32'h3C, 12'h118, 32'h3C,   8'd2},
        '{12'h11C, 32'h0F, 12'h110, 32'h33,   8'd4},
        '{12'h030, 32'hFF, 12'h030, 32'h00,   8'd8},
        '{12'h080, 32'hFF, 12'h080, 32'h00,   8'd1},
        '{12'h300, 32'hFF, 12'h300, 32'h00,   8'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        idle(3);
        rst = 1'b0;
        #1;
        // R7: reset state at the pads and irq
        check("R7 pad_oe", 32'(pad_oe), 32'h0);
        check("R7 pad_out", 32'(pad_out), 32'h0);
        check("R7 irq", 32'(irq), 32'h0);

        for (int v = 0; v < 10; v++) begin
            bwrite(VEC[v].wa, VEC[v].wd);
            bread(VEC[v].ra, rd);
            check($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].ex);
        end

        // R5: I/O mode pads follow output regs (dout bank0 = F0)
        bwrite(12'h010, 32'hFF);
        #1;
        check("R5 pad_oe", 32'(pad_oe[7:0]), 32'hFF);
        check("R5 pad_out", 32'(pad_out[7:0]), 32'hF0);

        // R6: pin 4 to function 1 -> per index 13
        bwrite(12'h008, 32'h0200);
        #1;
        check("R6 pad_out from per", 32'(pad_out[4]), 32'h0);
        check("R6 pad_oe from per", 32'(pad_oe[4]), 32'h0);
        @(negedge clk);
        per_out[13] = 1'b1; per_oe[13] = 1'b1;
        #1;
        check("R6 pad_out follows per", 32'(pad_out[4]), 32'h1);
        check("R6 pad_oe follows per", 32'(pad_oe[4]), 32'h1);
        bwrite(12'h028, 32'h10);
        bwrite(12'h018, 32'h10);
        #1;
        check("R6 dout ignored", 32'(pad_out[4]), 32'h1);
        check("R6 oe ignored", 32'(pad_oe[4]), 32'h1);

        // R8: two-flop input latency
        @(negedge clk);
        pad_in[3] = 1'b1;
        bread(12'h030, rd);
        check("R8 din after one edge", rd, 32'h0);
        bread(12'h030, rd);
        check("R8 din after two edges", rd, 32'h08);

        // R9: level-high interrupt on bank0 pin3
        bwrite(12'h064, 32'h08);
        bwrite(12'h044, 32'h08);
        idle(2);
        bread(12'h070, rd);
        check("R9 level status", rd, 32'h08);
        check("R12 irq bank0", 32'(irq), 32'h1);

        // R11: sticky status, only clear alias clears
        @(negedge clk);
        pad_in[3] = 1'b0;
        idle(4);
        bread(12'h070, rd);
        check("R11 sticky after level drop", rd, 32'h08);
        bwrite(12'h070, 32'h0);
        bwrite(12'h07C, 32'h08);
        bread(12'h070, rd);
        check("R11 plain/toggle ignored", rd, 32'h08);
        bwrite(12'h078, 32'h08);
        bread(12'h070, rd);
        check("R11 clear alias", rd, 32'h0);
        check("R12 irq drops", 32'(irq), 32'h0);

        // R10: falling-edge interrupt on bank1 pin2 (global 10)
        bwrite(12'h154, 32'h04);
        bwrite(12'h144, 32'h04);
        @(negedge clk);
        pad_in[10] = 1'b1;
        idle(4);
        bread(12'h170, rd);
        check("R10 rising ignored", rd, 32'h0);
        @(negedge clk);
        pad_in[10] = 1'b0;
        idle(4);
        bread(12'h170, rd);
        check("R10 falling edge", rd, 32'h04);
        check("R12 irq bank1", 32'(irq), 32'h2);

        // R12: disable masks irq while status stays
        bwrite(12'h148, 32'h04);
        #1;
        check("R12 irq masked", 32'(irq), 32'h0);
        bread(12'h170, rd);
        check("R11 status kept", rd, 32'h04);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule